// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns one already-arbitrated exception request into the complete processor state change that the exception needs, and does it in a single clock step. From the current program counter and the status word it holds, it computes four values. The first is the link value that the handler later uses to resume. The second is a saved copy of the status word. The third is the new status word, with the handler mode, the forced 32-bit instruction state and the interrupt masks applied. The fourth is the fetch address in the exception vector table. Configuration inputs choose whether fast interrupts, normal interrupts and external aborts run in their own modes or in the secure monitor mode. A vector-base select chooses between the low and the high vector table.

The block owns the live status register. After reset it builds the defined boot state and redirects fetch to the reset vector. It also takes the return path, in which a saved status word is copied back into the live one. Because of this, a handler that returns sees exactly the instruction state and mask flags it was interrupted with. Request arbitration, banked register storage and instruction decode belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: The link value `lr_o` is `pc_i`+8 for a data abort. It is `pc_i`+2 for a supervisor call or undefined instruction taken in 16-bit state (status bit 5 set, bit 24 clear). It is 0 for the reset kind. It is `pc_i`+4 in every other case, including 32-bit state (bits 5 and 24 clear) and bytecode state (bit 24 set).
- R2: A request with `exc_valid_i` high at a clock edge makes `entry_o` high for exactly the following cycle. In that cycle `spsr_o` holds the status word from before the entry.
- R3: `exc_kind_i` codes are 0 reset, 1 undefined, 2 supervisor call, 3 monitor call, 4 prefetch abort, 5 data abort, 6 IRQ, 7 FIQ and 8 breakpoint; codes 9 to 15 act as undefined. The new mode field (status bits 4:0) is 10011 for reset and supervisor call, 11011 for undefined, 10110 for monitor call, 10111 for aborts and breakpoint, 10010 for IRQ and 10001 for FIQ.
- R4: Entry clears status bits 5 (T) and 24 (J). It keeps every status bit outside the mode field, T, J and the masks, for example the condition flags and bit 9 (E).
- R5: While `rst_ni` is low, and after it is released, the status word holds mode 10011, with A (bit 8), I (bit 7) and F (bit 6) set, T and J clear, and `ns_o` clear. On the first clock after release, bit 9 loads from `endian_init_i` and `vec_o` takes the reset vector.
- R6: An FIQ entry sets F and I. Every other entry sets I. The reset kind sets A, I and F.
- R7: With `ret_valid_i` high and no request, the status word becomes `ret_spsr_i` on the next cycle, so T, J, A, I and F return to their saved values.
- R8: `cfg_fiq_mon_i` sends FIQ to monitor mode and `cfg_irq_mon_i` sends IRQ to monitor mode. `cfg_ea_mon_i` sends an abort that has `exc_ext_abort_i` set to monitor mode. If these inputs are clear, each of these exceptions enters its own mode.
- R9: Any entry whose resulting mode is abort (10111) also sets A.
- R10: `vec_o` is the base plus the offset 0x00 reset, 0x04 undefined, 0x08 supervisor or monitor call, 0x0C prefetch abort or breakpoint, 0x10 data abort, 0x18 IRQ or 0x1C FIQ. The base is 0xFFFF0000 when `hivec_i` is high and 0x00000000 when it is low.
- R11: A request and a return in the same cycle perform the entry and drop the return. A return also loads `ns_o` from `ret_ns_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hivec_i | input | 1 | Selects the high vector base |
| endian_init_i | input | 1 | Boot value of the endianness bit |
| cfg_fiq_mon_i | input | 1 | Route FIQ to monitor mode |
| cfg_irq_mon_i | input | 1 | Route IRQ to monitor mode |
| cfg_ea_mon_i | input | 1 | Route external aborts to monitor mode |
| exc_valid_i | input | 1 | Exception request this cycle |
| exc_kind_i | input | 4 | Exception kind code |
| exc_ext_abort_i | input | 1 | The abort is external |
| pc_i | input | 32 | Address of the affected instruction |
| ret_valid_i | input | 1 | Exception return this cycle |
| ret_spsr_i | input | 32 | Saved status word to restore |
| ret_ns_i | input | 1 | Security world to resume in |
| entry_o | output | 1 | Entry performed last cycle |
| lr_o | output | 32 | Link value |
| spsr_o | output | 32 | Status word before entry |
| vec_o | output | 32 | Vector fetch address |
| cpsr_o | output | 32 | Live status word |
| ns_o | output | 1 | Non-secure state bit |

## Verification
The bench targets the link offset matrix. It enters the same exceptions from 32-bit, 16-bit and bytecode state, where a design that ignores the instruction state would return two bytes off or land in the middle of an instruction. Each entry is made from a status word with T or J set and with the condition flags set. A design that forgets to force 32-bit state, or that clobbers unrelated bits, then runs the handler in the wrong decoder or corrupts the interrupted program's flags. The routing inputs and the external-abort flag are switched one at a time, to catch an abort that lands in monitor mode with A set, or an interrupt that ignores its route. Same-cycle entry and return, the reset kind and the high vector base are also driven, because a wrong priority would silently drop an exception.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [3:0] {
    EK_RESET = 4'd0,
    EK_UNDEF = 4'd1,
    EK_SVC   = 4'd2,
    EK_SMC   = 4'd3,
    EK_PABT  = 4'd4,
    EK_DABT  = 4'd5,
    EK_IRQ   = 4'd6,
    EK_FIQ   = 4'd7,
    EK_BKPT  = 4'd8
  } exc_kind_e;

  typedef enum logic [1:0] {
    ISA_WORD  = 2'd0,
    ISA_HALF  = 2'd1,
    ISA_BYTE  = 2'd2
  } isa_e;

  localparam int unsigned ST_T = 5;
  localparam int unsigned ST_F = 6;
  localparam int unsigned ST_I = 7;
  localparam int unsigned ST_A = 8;
  localparam int unsigned ST_E = 9;
  localparam int unsigned ST_J = 24;

  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_MON = 5'b10110;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;

  // mask set vector order: {A, I, F}
  typedef logic [2:0] mask_set_t;

endpackage

// File: rtl/exc_lr_calc.sv
module exc_lr_calc
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  exc_kind_e         kind_i,
  input  isa_e              isa_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [XLEN-1:0]   lr_o
);

  localparam int unsigned OFF_W = 4;

  logic [OFF_W-1:0] offset;

  always_comb begin
    offset = OFF_W'(4);
    if (kind_i == EK_DABT) begin
      offset = OFF_W'(8);
    end else if ((kind_i == EK_SVC || kind_i == EK_UNDEF) && isa_i == ISA_HALF) begin
      offset = OFF_W'(2);
    end
  end

  always_comb begin
    if (kind_i == EK_RESET) begin
      lr_o = '0;
    end else begin
      lr_o = pc_i + XLEN'(offset);
    end
  end

endmodule

// File: rtl/exc_route.sv
module exc_route
  import exc_seq_pkg::*;
#(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] LOVEC_BASE = '0,
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  exc_kind_e       kind_i,
  input  logic            ext_abort_i,
  input  logic            cfg_fiq_mon_i,
  input  logic            cfg_irq_mon_i,
  input  logic            cfg_ea_mon_i,
  input  logic            hivec_i,
  output logic [4:0]      mode_o,
  output mask_set_t       mask_o,
  output logic [XLEN-1:0] base_o,
  output logic [XLEN-1:0] vec_o
);

  localparam int unsigned VOFF_W = 5;

  logic [VOFF_W-1:0] voff;
  logic [4:0]        mode_raw;
  mask_set_t         mask_raw;
  logic              abort_to_mon;

  assign abort_to_mon = ext_abort_i & cfg_ea_mon_i;
  assign base_o       = hivec_i ? HIVEC_BASE : LOVEC_BASE;

  always_comb begin
    mode_raw = MD_UND;
    mask_raw = 3'b010;
    voff     = VOFF_W'(5'h04);
    unique case (kind_i)
      EK_RESET: begin mode_raw = MD_SVC; mask_raw = 3'b111; voff = VOFF_W'(5'h00); end
      EK_UNDEF: begin mode_raw = MD_UND; voff = VOFF_W'(5'h04); end
      EK_SVC:   begin mode_raw = MD_SVC; voff = VOFF_W'(5'h08); end
      EK_SMC:   begin mode_raw = MD_MON; voff = VOFF_W'(5'h08); end
      EK_PABT:  begin mode_raw = abort_to_mon ? MD_MON : MD_ABT; voff = VOFF_W'(5'h0C); end
      EK_DABT:  begin mode_raw = abort_to_mon ? MD_MON : MD_ABT; voff = VOFF_W'(5'h10); end
      EK_IRQ:   begin mode_raw = cfg_irq_mon_i ? MD_MON : MD_IRQ; voff = VOFF_W'(5'h18); end
      EK_FIQ:   begin
        mode_raw = cfg_fiq_mon_i ? MD_MON : MD_FIQ;
        mask_raw = 3'b011;
        voff     = VOFF_W'(5'h1C);
      end
      EK_BKPT:  begin mode_raw = MD_ABT; voff = VOFF_W'(5'h0C); end
      default:  begin mode_raw = MD_UND; voff = VOFF_W'(5'h04); end
    endcase
  end

  always_comb begin
    mode_o = mode_raw;
    mask_o = mask_raw;
    if (mode_raw == MD_ABT) begin
      mask_o[2] = 1'b1;
    end
  end

  assign vec_o = base_o | XLEN'(voff);

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            endian_init_i,
  input  logic [XLEN-1:0] boot_vec_i,
  input  logic            exc_valid_i,
  input  logic [4:0]      mode_i,
  input  mask_set_t       mask_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] vec_i,
  input  logic            ret_valid_i,
  input  logic [31:0]     ret_spsr_i,
  input  logic            ret_ns_i,
  output logic            entry_o,
  output logic [XLEN-1:0] lr_o,
  output logic [31:0]     spsr_o,
  output logic [XLEN-1:0] vec_o,
  output logic [31:0]     cpsr_o,
  output logic            ns_o
);

  localparam logic [31:0] CPSR_RST = 32'h0000_01D3;

  logic            boot_q, boot_d;
  logic [31:0]     cpsr_q, cpsr_d;
  logic [31:0]     spsr_q, spsr_d;
  logic [XLEN-1:0] lr_q, lr_d;
  logic [XLEN-1:0] vec_q, vec_d;
  logic            entry_q, entry_d;
  logic            ns_q, ns_d;
  logic            cpsr_en, spsr_en, lr_en, vec_en, ns_en;

  // next-state process
  always_comb begin
    boot_d  = 1'b0;
    entry_d = 1'b0;
    cpsr_d  = cpsr_q;
    spsr_d  = cpsr_q;
    lr_d    = lr_i;
    vec_d   = vec_i;
    ns_d    = ret_ns_i;
    cpsr_en = 1'b0;
    spsr_en = 1'b0;
    lr_en   = 1'b0;
    vec_en  = 1'b0;
    ns_en   = 1'b0;
    if (boot_q) begin
      cpsr_d[ST_E] = endian_init_i;
      cpsr_en      = 1'b1;
      vec_d        = boot_vec_i;
      vec_en       = 1'b1;
    end else if (exc_valid_i) begin
      entry_d      = 1'b1;
      cpsr_d[4:0]  = mode_i;
      cpsr_d[ST_T] = 1'b0;
      cpsr_d[ST_J] = 1'b0;
      cpsr_d[ST_A] = cpsr_q[ST_A] | mask_i[2];
      cpsr_d[ST_I] = cpsr_q[ST_I] | mask_i[1];
      cpsr_d[ST_F] = cpsr_q[ST_F] | mask_i[0];
      cpsr_en      = 1'b1;
      spsr_en      = 1'b1;
      lr_en        = 1'b1;
      vec_en       = 1'b1;
    end else if (ret_valid_i) begin
      cpsr_d  = ret_spsr_i;
      cpsr_en = 1'b1;
      ns_en   = 1'b1;
    end
  end

  // register process
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      entry_q <= 1'b0;
      cpsr_q  <= CPSR_RST;
      spsr_q  <= '0;
      lr_q    <= '0;
      vec_q   <= '0;
      ns_q    <= 1'b0;
    end else begin
      boot_q  <= boot_d;
      entry_q <= entry_d;
      if (cpsr_en) cpsr_q <= cpsr_d;
      if (spsr_en) spsr_q <= spsr_d;
      if (lr_en)   lr_q   <= lr_d;
      if (vec_en)  vec_q  <= vec_d;
      if (ns_en)   ns_q   <= ns_d;
    end
  end

  assign entry_o = entry_q;
  assign lr_o    = lr_q;
  assign spsr_o  = spsr_q;
  assign vec_o   = vec_q;
  assign cpsr_o  = cpsr_q;
  assign ns_o    = ns_q;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] LOVEC_BASE = '0,
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hivec_i,
  input  logic            endian_init_i,
  input  logic            cfg_fiq_mon_i,
  input  logic            cfg_irq_mon_i,
  input  logic            cfg_ea_mon_i,
  input  logic            exc_valid_i,
  input  logic [3:0]      exc_kind_i,
  input  logic            exc_ext_abort_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ret_valid_i,
  input  logic [31:0]     ret_spsr_i,
  input  logic            ret_ns_i,
  output logic            entry_o,
  output logic [XLEN-1:0] lr_o,
  output logic [31:0]     spsr_o,
  output logic [XLEN-1:0] vec_o,
  output logic [31:0]     cpsr_o,
  output logic            ns_o
);

  exc_kind_e       kind_n;
  isa_e            isa;
  logic [4:0]      new_mode;
  mask_set_t       new_mask;
  logic [XLEN-1:0] lr_nxt;
  logic [XLEN-1:0] vec_nxt;
  logic [XLEN-1:0] base;
  logic [31:0]     cpsr_q;

  // codes past the last defined kind behave as undefined instruction
  assign kind_n = (exc_kind_i > 4'd8) ? EK_UNDEF : exc_kind_e'(exc_kind_i);

  always_comb begin
    if (cpsr_q[ST_J])      isa = ISA_BYTE;
    else if (cpsr_q[ST_T]) isa = ISA_HALF;
    else                   isa = ISA_WORD;
  end

  exc_lr_calc #(.XLEN(XLEN)) u_lr (
    .kind_i (kind_n),
    .isa_i  (isa),
    .pc_i   (pc_i),
    .lr_o   (lr_nxt)
  );

  exc_route #(
    .XLEN       (XLEN),
    .LOVEC_BASE (LOVEC_BASE),
    .HIVEC_BASE (HIVEC_BASE)
  ) u_route (
    .kind_i        (kind_n),
    .ext_abort_i   (exc_ext_abort_i),
    .cfg_fiq_mon_i (cfg_fiq_mon_i),
    .cfg_irq_mon_i (cfg_irq_mon_i),
    .cfg_ea_mon_i  (cfg_ea_mon_i),
    .hivec_i       (hivec_i),
    .mode_o        (new_mode),
    .mask_o        (new_mask),
    .base_o        (base),
    .vec_o         (vec_nxt)
  );

  exc_status_reg #(.XLEN(XLEN)) u_stat (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .endian_init_i (endian_init_i),
    .boot_vec_i    (base),
    .exc_valid_i   (exc_valid_i),
    .mode_i        (new_mode),
    .mask_i        (new_mask),
    .lr_i          (lr_nxt),
    .vec_i         (vec_nxt),
    .ret_valid_i   (ret_valid_i),
    .ret_spsr_i    (ret_spsr_i),
    .ret_ns_i      (ret_ns_i),
    .entry_o       (entry_o),
    .lr_o          (lr_o),
    .spsr_o        (spsr_o),
    .vec_o         (vec_o),
    .cpsr_o        (cpsr_q),
    .ns_o          (ns_o)
  );

  assign cpsr_o = cpsr_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_valid_i,
  input logic [3:0]      exc_kind_i,
  input logic            ret_valid_i,
  input logic [31:0]     ret_spsr_i,
  input logic            entry_o,
  input logic [XLEN-1:0] vec_o,
  input logic [31:0]     spsr_o,
  input logic [31:0]     cpsr_o
);

  AST_ENTRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> entry_o); // R2

  AST_SPSR_PRIOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> spsr_o == $past(cpsr_o)); // R2

  AST_STATE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> (!cpsr_o[5] && !cpsr_o[24])); // R4

  AST_FIQ_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_kind_i == 4'd7) |=> (cpsr_o[6] && cpsr_o[7])); // R6

  AST_RETURN_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_i && !exc_valid_i && !entry_o && $past(rst_ni)) |=> cpsr_o == $past(ret_spsr_i)); // R7

  AST_ABORT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_o && cpsr_o[4:0] == 5'b10111) |-> cpsr_o[8]); // R9

  AST_VEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_o |-> vec_o[1:0] == 2'b00); // R10

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_valid_i (exc_valid_i),
  .exc_kind_i  (exc_kind_i),
  .ret_valid_i (ret_valid_i),
  .ret_spsr_i  (ret_spsr_i),
  .entry_o     (entry_o),
  .vec_o       (vec_o),
  .spsr_o      (spsr_o),
  .cpsr_o      (cpsr_o)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hivec, endian_init, cfg_fiq, cfg_irq, cfg_ea;
  logic        exc_valid, ext_abort, ret_valid, ret_ns;
  logic [3:0]  exc_kind;
  logic [31:0] pc, ret_spsr;
  logic        entry;
  logic [31:0] lr, spsr, vec, cpsr;
  logic        ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  exc_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hivec_i(hivec), .endian_init_i(endian_init),
    .cfg_fiq_mon_i(cfg_fiq), .cfg_irq_mon_i(cfg_irq), .cfg_ea_mon_i(cfg_ea),
    .exc_valid_i(exc_valid), .exc_kind_i(exc_kind), .exc_ext_abort_i(ext_abort),
    .pc_i(pc), .ret_valid_i(ret_valid), .ret_spsr_i(ret_spsr), .ret_ns_i(ret_ns),
    .entry_o(entry), .lr_o(lr), .spsr_o(spsr), .vec_o(vec), .cpsr_o(cpsr), .ns_o(ns)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load_status(logic [31:0] val, logic nsv);
    @(negedge clk);
    ret_valid = 1'b1; ret_spsr = val; ret_ns = nsv;
    @(negedge clk);
    ret_valid = 1'b0;
    check("R7 status after return", cpsr, val);
    check("R11 ns after return", {31'b0, ns}, {31'b0, nsv});
  endtask

  task automatic take(string tag, logic [3:0] kind, logic [31:0] pcv, logic ext,
                      logic [31:0] exp_lr, logic [31:0] exp_cpsr, logic [31:0] exp_vec);
    logic [31:0] prior;
    prior = cpsr;
    @(negedge clk);
    exc_valid = 1'b1; exc_kind = kind; pc = pcv; ext_abort = ext;
    @(negedge clk);
    exc_valid = 1'b0; ext_abort = 1'b0;
    check({tag, " R2 entry"}, {31'b0, entry}, 32'd1);
    check({tag, " R1 link"}, lr, exp_lr);
    check({tag, " R2 saved status"}, spsr, prior);
    check({tag, " R3/R4/R6 status"}, cpsr, exp_cpsr);
    check({tag, " R10 vector"}, vec, exp_vec);
    @(negedge clk);
    check({tag, " R2 entry pulse ends"}, {31'b0, entry}, 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 reset status", cpsr, 32'h0000_01D3);
    check("R5 reset ns", {31'b0, ns}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 boot endian", cpsr, 32'h0000_03D3);
    check("R5 boot vector", vec, 32'h0);
    check("R5 no entry at boot", {31'b0, entry}, 32'd0);
  endtask

  task automatic t_word_state;
    load_status(32'h8000_0210, 1'b0);
    take("svc word R1", 4'd2, 32'h1000, 1'b0, 32'h1004, 32'h8000_0293, 32'h08);
    load_status(32'h0000_0210, 1'b0);
    take("smc word R3", 4'd3, 32'h8000, 1'b0, 32'h8004, 32'h0000_0296, 32'h08);
  endtask

  task automatic t_half_state;
    load_status(32'h0000_0230, 1'b0);
    take("svc half R1 R4", 4'd2, 32'h2002, 1'b0, 32'h2004, 32'h0000_0293, 32'h08);
    load_status(32'h0000_0230, 1'b0);
    take("und half R1", 4'd1, 32'h3000, 1'b0, 32'h3002, 32'h0000_029B, 32'h04);
    load_status(32'h0000_0230, 1'b0);
    take("fiq half R6", 4'd7, 32'h5000, 1'b0, 32'h5004, 32'h0000_02D1, 32'h1C);
  endtask

  task automatic t_byte_state;
    load_status(32'h0100_0210, 1'b0);
    take("dabt byte R1 R9", 4'd5, 32'h4000, 1'b0, 32'h4008, 32'h0000_0397, 32'h10);
    load_status(32'h0100_0210, 1'b0);
    take("svc byte R1", 4'd2, 32'h4100, 1'b0, 32'h4104, 32'h0000_0293, 32'h08);
  endtask

  task automatic t_routing;
    cfg_irq = 1'b1;
    load_status(32'h0000_0210, 1'b0);
    take("irq mon R8", 4'd6, 32'h6000, 1'b0, 32'h6004, 32'h0000_0296, 32'h18);
    cfg_irq = 1'b0;
    load_status(32'h0000_0210, 1'b0);
    take("irq own R8", 4'd6, 32'h6000, 1'b0, 32'h6004, 32'h0000_0292, 32'h18);
    cfg_fiq = 1'b1;
    load_status(32'h0000_0210, 1'b0);
    take("fiq mon R8", 4'd7, 32'h6100, 1'b0, 32'h6104, 32'h0000_02D6, 32'h1C);
    cfg_fiq = 1'b0;
    cfg_ea = 1'b1;
    load_status(32'h0000_0210, 1'b0);
    take("pabt ext R8", 4'd4, 32'h6200, 1'b1, 32'h6204, 32'h0000_0296, 32'h0C);
    load_status(32'h0000_0210, 1'b0);
    take("pabt int R9", 4'd4, 32'h6300, 1'b0, 32'h6304, 32'h0000_0397, 32'h0C);
    cfg_ea = 1'b0;
  endtask

  task automatic t_high_vectors;
    hivec = 1'b1;
    load_status(32'h0000_0230, 1'b0);
    take("bkpt high R10", 4'd8, 32'h7000, 1'b0, 32'h7004, 32'h0000_0397, 32'hFFFF_000C);
    hivec = 1'b0;
  endtask

  task automatic t_reset_kind;
    load_status(32'h0000_0210, 1'b0);
    take("reset kind R6", 4'd0, 32'h9000, 1'b0, 32'h0, 32'h0000_03D3, 32'h00);
  endtask

  task automatic t_return_restore;
    load_status(32'h0000_0230, 1'b0);
    take("fiq before ret R6", 4'd7, 32'h5000, 1'b0, 32'h5004, 32'h0000_02D1, 32'h1C);
    load_status(spsr, 1'b1);
    check("R7 T restored", cpsr, 32'h0000_0230);
  endtask

  task automatic t_collision;
    load_status(32'h0000_0210, 1'b0);
    @(negedge clk);
    exc_valid = 1'b1; exc_kind = 4'd2; pc = 32'hA000;
    ret_valid = 1'b1; ret_spsr = 32'hFFFF_FFFF; ret_ns = 1'b1;
    @(negedge clk);
    exc_valid = 1'b0; ret_valid = 1'b0;
    check("R11 entry wins status", cpsr, 32'h0000_0293);
    check("R11 ns untouched", {31'b0, ns}, 32'd0);
    check("R11 link", lr, 32'hA004);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    hivec = 0; endian_init = 1; cfg_fiq = 0; cfg_irq = 0; cfg_ea = 0;
    exc_valid = 0; exc_kind = 0; ext_abort = 0; pc = 0;
    ret_valid = 0; ret_spsr = 0; ret_ns = 0;
    t_reset();
    t_word_state();
    t_half_state();
    t_byte_state();
    t_routing();
    t_high_vectors();
    t_reset_kind();
    t_return_restore();
    t_collision();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule